// File: doc/BRIEF.md
# ADC Conversion Sequencer and Status Registers

This block is the digital side of a successive-approximation analog-to-digital converter. A processor reaches it through two byte registers: a control/status register and a result register. The control/status register holds a continuous-run bit, an interrupt-enable bit, a 5-bit input selector and a read-only completion flag. The block starts conversions on an external converter core, latches each result the core returns, keeps the completion flag and raises an interrupt request. It also powers the core down when the selector holds the all-ones code.

A processor starts a conversion by writing the control/status register. In single mode the block runs one conversion and then stops. In continuous mode it starts the next conversion each time one finishes. A stop-mode input halts the block at once and abandons any conversion in progress. When stop mode ends, the block starts again. The first conversion after that is only a settling pass: its result is dropped and the block runs another conversion straight away.

Top module: `adc_ctrl`

## Requirements
- R1: After reset, the control/status register reads 8'h1F (selector at the power-down code 31, other bits zero), the result register reads 0, `irq` is low and `conv_pwr_en` is low.
- R2: The control/status register is at `reg_addr`=0 and the result register is at `reg_addr`=1. In the control/status register, bit 7 is the completion flag (read-only), bit 6 is interrupt enable, bit 5 is continuous run and bits 4:0 are the selector. A write with a selector from 0 to 14 raises `conv_start` for exactly one cycle, in the cycle after the write, with `conv_chan` equal to the selector.
- R3: In single mode, one conversion runs. On the `conv_done` cycle its result is loaded into the result register and the flag is set. No further start follows.
- R4: In continuous mode, each accepted `conv_done` starts another conversion. This repeats until software clears the continuous bit. Each new result overwrites the result register, even if the previous one was never read.
- R5: The flag is cleared by any write to the control/status register and by any read of the result register. A read of the control/status register leaves it unchanged.
- R6: While interrupt enable is set, `irq` follows the flag, and bit 7 of the control/status register reads as 0.
- R7: Selector code 31 holds `conv_pwr_en` low and starts no conversion.
- R8: Selector codes 15 to 30 start no conversion, while `conv_pwr_en` stays high.
- R9: A control/status write during a conversion abandons that conversion and starts a new one on the newly written selector.
- R10: While `stop_mode` is high, `conv_pwr_en` is low, no conversion starts, and a `conv_done` changes neither the flag nor the result register.
- R11: When `stop_mode` falls, a conversion that was running, or continuous mode, starts again. The first result after that is discarded and does not set the flag. A further conversion then runs, and its result is stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (its side effects take place at the clock edge) |
| reg_addr | input | 1 | 0 = control/status, 1 = result |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| stop_mode | input | 1 | High while the device is stopped |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_chan | output | 5 | Selected input for the core |
| conv_pwr_en | output | 1 | Converter core power enable |
| conv_done | input | 1 | One-cycle completion pulse from the core |
| conv_result | input | 8 | Core result, valid with `conv_done` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is stop mode arriving while a conversion is running, with the core still reporting that conversion's completion during the stop. The block must then restart after the stop and throw away exactly one result. The stimulus starts a single conversion and raises `stop_mode` two cycles later. It lets the responder model deliver its late `conv_done` during the stop, and then releases the stop. After that it checks that two start pulses follow and that the result register moves only on the second completion.

// File: rtl/adc_ctrl_pkg.sv
// Package: shared widths, register selector encoding and control-field layout
// for the ADC conversion sequencer. Assumes the control image fits in DATA_W.
package adc_ctrl_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned CHAN_W   = 5;
    localparam int unsigned NUM_CHAN = 15;
    localparam int unsigned CTRL_W   = CHAN_W + 3;

    localparam logic [CHAN_W-1:0] CHAN_OFF = '1;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic              ien;
        logic              cont;
        logic [CHAN_W-1:0] chan;
    } ctrl_t;

    // True for selector codes that name a real analog input.
    function automatic logic chan_ok(input logic [CHAN_W-1:0] c);
        return c < CHAN_W'(NUM_CHAN);
    endfunction
endpackage

// File: rtl/adc_ctrl_regs.sv
// Module: control fields, completion flag and result register.
// Assumes ctrl_wr and data_rd are single-cycle strobes already decoded.
// A new result takes priority over a flag clear in the same cycle.
module adc_ctrl_regs
    import adc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              data_rd,
    input  ctrl_t             ctrl_wdata,
    input  logic              result_vld,
    input  logic [DATA_W-1:0] result,
    output ctrl_t             ctrl_q,
    output logic              flag_q,
    output logic [DATA_W-1:0] data_q
);
    // Control fields: load on write, reset to power-down selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{ien: 1'b0, cont: 1'b0, chan: CHAN_OFF};
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_wdata;
        end
    end

    // Completion flag: set by an accepted result, cleared by write or data read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (result_vld) begin
            flag_q <= 1'b1;
        end else if (ctrl_wr || data_rd) begin
            flag_q <= 1'b0;
        end
    end

    // Result register: overwritten by every accepted result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (result_vld) begin
            data_q <= result;
        end
    end
endmodule

// File: rtl/adc_ctrl_seq.sv
// Module: conversion sequencer. Issues start pulses, tracks the running
// conversion, restarts it in continuous mode, aborts it on a register write or
// on stop mode, and runs one discarded settling pass after stop mode ends.
// Assumes the core answers each start with at most one done pulse.
module adc_ctrl_seq
    import adc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CHAN_W-1:0] new_chan,
    input  logic              cont,
    input  logic [CHAN_W-1:0] chan,
    input  logic              stop,
    input  logic              conv_done,
    output logic              start_q,
    output logic              busy_q,
    output logic              result_vld
);
    logic stop_q;
    logic discard_q;
    logic resume_q;
    logic stop_exit;

    assign stop_exit = stop_q && !stop;

    // A completion counts only for a live, non-settling, non-aborted conversion.
    assign result_vld = busy_q && conv_done && !discard_q && !stop && !ctrl_wr;

    // Registered copy of stop mode, used to detect its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_q <= 1'b0;
        else        stop_q <= stop;
    end

    // Sequencer state: start pulse, busy, settling and resume flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            busy_q    <= 1'b0;
            discard_q <= 1'b0;
            resume_q  <= 1'b0;
        end else if (stop) begin
            start_q   <= 1'b0;
            busy_q    <= 1'b0;
            discard_q <= 1'b0;
            if (busy_q || (cont && chan_ok(chan)) || (ctrl_wr && chan_ok(new_chan)))
                resume_q <= 1'b1;
        end else begin
            start_q <= 1'b0;
            if (ctrl_wr) begin
                resume_q <= 1'b0;
                if (chan_ok(new_chan)) begin
                    start_q   <= 1'b1;
                    busy_q    <= 1'b1;
                    discard_q <= stop_exit;
                end else begin
                    busy_q    <= 1'b0;
                    discard_q <= 1'b0;
                end
            end else if (stop_exit) begin
                resume_q <= 1'b0;
                if (resume_q && chan_ok(chan)) begin
                    start_q   <= 1'b1;
                    busy_q    <= 1'b1;
                    discard_q <= 1'b1;
                end
            end else if (busy_q && conv_done) begin
                if (discard_q) begin
                    discard_q <= 1'b0;
                    start_q   <= 1'b1;
                end else if (cont && chan_ok(chan)) begin
                    start_q <= 1'b1;
                end else begin
                    busy_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/adc_ctrl.sv
// Module: top of the ADC conversion sequencer. Decodes the two-register
// processor port, builds the read image and the interrupt, and wires the
// register and sequencer blocks to the converter-core handshake.
// Assumes reg_wr and reg_rd are not asserted together.
module adc_ctrl
    import adc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              stop_mode,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              conv_pwr_en,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    output logic              irq
);
    ctrl_t             ctrl_q;
    ctrl_t             ctrl_wdata;
    logic              flag_q;
    logic [DATA_W-1:0] data_q;
    logic              ctrl_wr;
    logic              data_rd;
    logic              result_vld;
    logic              busy_q;
    logic [CTRL_W-1:0] ctrl_image;

    assign ctrl_wr    = reg_wr && (reg_sel_e'(reg_addr) == SEL_CTRL);
    assign data_rd    = reg_rd && (reg_sel_e'(reg_addr) == SEL_DATA);
    assign ctrl_wdata = ctrl_t'(reg_wdata[CTRL_W-2:0]);

    adc_ctrl_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .data_rd    (data_rd),
        .ctrl_wdata (ctrl_wdata),
        .result_vld (result_vld),
        .result     (conv_result),
        .ctrl_q     (ctrl_q),
        .flag_q     (flag_q),
        .data_q     (data_q)
    );

    adc_ctrl_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .new_chan   (ctrl_wdata.chan),
        .cont       (ctrl_q.cont),
        .chan       (ctrl_q.chan),
        .stop       (stop_mode),
        .conv_done  (conv_done),
        .start_q    (conv_start),
        .busy_q     (busy_q),
        .result_vld (result_vld)
    );

    // Read image: the flag is hidden while the interrupt path owns it.
    assign ctrl_image = {flag_q && !ctrl_q.ien, ctrl_q};

    // Read data mux for the two registers.
    always_comb begin
        if (reg_sel_e'(reg_addr) == SEL_DATA) reg_rdata = data_q;
        else                                  reg_rdata = DATA_W'(ctrl_image);
    end

    assign conv_chan   = ctrl_q.chan;
    assign conv_pwr_en = (ctrl_q.chan != CHAN_OFF) && !stop_mode;
    assign irq         = flag_q && ctrl_q.ien;
endmodule

// File: rtl/adc_ctrl_chk.sv
// Checker: temporal properties of the ADC sequencer, bound to adc_ctrl.
module adc_ctrl_chk
    import adc_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic              stop_mode,
    input logic              conv_start,
    input logic [CHAN_W-1:0] conv_chan,
    input logic              conv_pwr_en,
    input logic              conv_done,
    input logic              irq,
    input logic              flag_q,
    input logic [DATA_W-1:0] data_q
);
    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R8
    start_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan < CHAN_W'(NUM_CHAN)));
    // R7
    pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_chan == CHAN_OFF) |-> !conv_pwr_en);
    // R10
    stop_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && $past(stop_mode)) |-> !conv_start);
    // R10
    stop_hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> $stable(data_q));
    // R3
    data_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(data_q));
    // R5
    write_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr) |=> !flag_q);
    // R6
    irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(conv_done));
endmodule

bind adc_ctrl adc_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .stop_mode   (stop_mode),
    .conv_start  (conv_start),
    .conv_chan   (conv_chan),
    .conv_pwr_en (conv_pwr_en),
    .conv_done   (conv_done),
    .irq         (irq),
    .flag_q      (flag_q),
    .data_q      (data_q)
);

// File: tb/adc_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for adc_ctrl with a converter-core responder model.
module adc_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       stop_mode = 1'b0;
    logic       conv_start;
    logic [4:0] conv_chan;
    logic       conv_pwr_en;
    logic       conv_done = 1'b0;
    logic [7:0] conv_result = '0;
    logic       irq;

    int errors = 0;
    int checks = 0;
    int starts = 0;
    logic [7:0] last_res = '0;
    logic [3:0] res_seq = '0;
    int lat_cnt = 0;

    always #2.5 clk = ~clk;

    adc_ctrl dut_i (.*);

    // Responder: done pulse four cycles after a start; a new start restarts it.
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            starts  <= starts + 1;
            lat_cnt <= 4;
        end else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                conv_done   <= 1'b1;
                conv_result <= {conv_chan[3:0], res_seq};
                last_res    <= {conv_chan[3:0], res_seq};
                res_seq     <= res_seq + 1'b1;
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_done();
        @(posedge clk iff conv_done);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); check(v == 8'h1F, "R1 ctrl", v, 8'h1F);
        rd(1'b1, v); check(v == 8'h00, "R1 data", v, 0);
        check(!irq && !conv_pwr_en, "R1 irq/pwr", {irq, conv_pwr_en}, 0);
    endtask

    task automatic t_single();
        logic [7:0] v;
        int s0;
        s0 = starts;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h03;
        @(negedge clk);
        reg_wr = 1'b0;
        check(conv_start && conv_chan == 5'd3, "R2 start pulse", {conv_start, conv_chan}, {1'b1, 5'd3});
        @(negedge clk);
        check(!conv_start, "R2 pulse width", conv_start, 0);
        wait_done();
        rd(1'b0, v); check(v == 8'h83, "R3 flag set", v, 8'h83);
        rd(1'b0, v); check(v == 8'h83, "R5 ctrl read keeps flag", v, 8'h83);
        rd(1'b1, v); check(v == last_res, "R3 data", v, last_res);
        rd(1'b0, v); check(v == 8'h03, "R5 data read clears flag", v, 8'h03);
        repeat (12) @(negedge clk);
        check(starts == s0 + 1, "R3 single only", starts - s0, 1);
    endtask

    task automatic t_cont();
        logic [7:0] v;
        int s0;
        s0 = starts;
        wr_ctrl(8'h25);
        repeat (3) wait_done();
        check(starts - s0 >= 3, "R4 restarts", starts - s0, 3);
        rd(1'b0, v); check(v == 8'hA5, "R4 flag stays", v, 8'hA5);
        wr_ctrl(8'h05);
        rd(1'b0, v); check(v == 8'h05, "R5 write clears flag", v, 8'h05);
        wait_done();
        rd(1'b1, v); check(v == last_res, "R4 overwrite", v, last_res);
        s0 = starts;
        repeat (12) @(negedge clk);
        check(starts == s0, "R4 stops when cleared", starts - s0, 0);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr_ctrl(8'h47);
        check(!irq, "R6 irq low before done", irq, 0);
        wait_done();
        check(irq, "R6 irq high", irq, 1);
        rd(1'b0, v); check(v == 8'h47, "R6 flag hidden", v, 8'h47);
        rd(1'b1, v);
        check(!irq, "R6 irq cleared by data read", irq, 0);
        wr_ctrl(8'h07);
        wait_done();
    endtask

    task automatic t_pwrdn();
        int s0;
        s0 = starts;
        wr_ctrl(8'h1F);
        repeat (15) @(negedge clk);
        check(starts == s0, "R7 no start", starts - s0, 0);
        check(!conv_pwr_en, "R7 power off", conv_pwr_en, 0);
        wr_ctrl(8'h0F);
        repeat (15) @(negedge clk);
        check(starts == s0 && conv_pwr_en, "R8 code 15", {starts - s0, 1'b0}, 1);
        wr_ctrl(8'h3E);
        repeat (15) @(negedge clk);
        check(starts == s0 && conv_pwr_en, "R8 code 30 cont", {starts - s0, 1'b0}, 1);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        int s0;
        s0 = starts;
        wr_ctrl(8'h02);
        wr_ctrl(8'h04);
        wait_done();
        rd(1'b1, v);
        check(v == last_res && v[7:4] == 4'd4, "R9 new channel result", v, {4'd4, last_res[3:0]});
        check(starts == s0 + 2, "R9 two starts", starts - s0, 2);
    endtask

    task automatic t_stop();
        logic [7:0] v;
        logic [7:0] old;
        int s0;
        rd(1'b1, old);
        wr_ctrl(8'h06);
        @(negedge clk);
        stop_mode = 1'b1;
        #1 check(!conv_pwr_en, "R10 power off in stop", conv_pwr_en, 0);
        s0 = starts;
        repeat (10) @(negedge clk);
        check(starts == s0, "R10 no start in stop", starts - s0, 0);
        rd(1'b0, v); check(v == 8'h06, "R10 no flag from aborted", v, 8'h06);
        rd(1'b1, v); check(v == old, "R10 data held", v, old);
        stop_mode = 1'b0;
        wait_done();
        rd(1'b0, v); check(v == 8'h06, "R11 settle no flag", v, 8'h06);
        rd(1'b1, v); check(v == old, "R11 settle discarded", v, old);
        wait_done();
        rd(1'b0, v); check(v == 8'h86, "R11 real result flag", v, 8'h86);
        rd(1'b1, v); check(v == last_res, "R11 real result data", v, last_res);
        check(starts == s0 + 2, "R11 two starts", starts - s0, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_cont();
        t_irq();
        t_pwrdn();
        t_abort();
        t_stop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule